// File: doc/BRIEF.md
# Multi-Frame Serial Peripheral Interface Master

This block is the master end of a serial peripheral interface link. One start command moves a group of one to four frames. Each frame can be any length from 8 to 16 bits, or 20, 24 or 32 bits. The host fills a 128-bit transmit store through a word-wide write port. Frame k is taken from 32-bit word k, right-aligned. When the transfer ends, the host finds the received frames in a 128-bit result register that uses the same layout.

The serial clock idles low and runs at a host-set fraction of the system clock. In four-wire operation, one of four active-low selects frames the whole group. In three-wire operation, every select stays high.

At the start edge, the controller takes a snapshot of the transmit store and latches all configuration. The host can therefore prepare the next group while the current one shifts. The result register is replaced only at the end of a group, so the previous result stays readable throughout a transfer.

Top module: `spi_multi_master`

## Requirements
- R1: The frame length is cfgFrameBits when that value is 8..16, 20, 24 or 32. Any other value gives 8-bit frames. Each frame produces exactly that many SCK pulses.
- R2: When cfgLsbFirst=1, each frame leaves and enters starting at bit 0. When cfgLsbFirst=0, it starts at bit (length-1).
- R3: cfgFrames+1 frames (1..4) are sent back to back. Frame k uses transmit word k, which is bits [32k+31:32k]. Bits at or above the frame length are not sent.
- R4: Received frame k lands right-aligned in rxData word k, and all other bits read 0. rxData changes only in the cycle done is high, so it holds the previous result during a transfer.
- R5: At the startReq edge, the transfer takes the transmit store as it stood before that edge. A txWrEn in the same cycle, or during the transfer, only affects later transfers.
- R6: In four-wire mode, only ssN[cfgSsSel] goes low while busy. With cfgThreeWire=1, ssN stays all ones.
- R7: SCK idles low and its high and low phases each last max(cfgSckHalf,1) clocks. MISO is sampled on the rising edge, and MOSI changes only while SCK is low.
- R8: The select falls one half-period before the first rising SCK edge and rises one half-period after the last falling edge. It stays low between frames.
- R9: done is a one-cycle pulse in the cycle the select releases and busy drops. rxFull is set then and cleared by rxRead. If rxRead coincides with done, the set wins.
- R10: A startReq while busy is ignored, and no extra transfer follows.
- R11: After reset, sck=0, mosi=0, ssN is all ones, and busy, done and rxFull are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txWrEn | input | 1 | Write one transmit word |
| txWrIdx | input | 2 | Transmit word index |
| txWrData | input | 32 | Transmit word value |
| startReq | input | 1 | Start a transfer (accepted when idle) |
| cfgFrameBits | input | 6 | Bits per frame |
| cfgLsbFirst | input | 1 | 1 = least significant bit first |
| cfgFrames | input | 2 | Frame count minus one |
| cfgSsSel | input | 2 | Select line used in four-wire mode |
| cfgThreeWire | input | 1 | 1 = no select asserted |
| cfgSckHalf | input | 8 | SCK half-period in clocks (0 acts as 1) |
| rxRead | input | 1 | Host acknowledges the result |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rxFull | output | 1 | Unread result present |
| rxData | output | 128 | Received frames, word k = frame k |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 4 | Active-low slave selects |

## Verification
Two host actions can fall in the same cycle as a controller event.

The first is a transmit-store write landing on the same edge that accepts startReq. The bench rewrites word 0 in that cycle and word 1 mid-transfer. It then expects the MOSI stream to carry the old words, and a second start without rewriting to carry the new ones.

The second is rxRead colliding with the end-of-transfer pulse. The bench holds rxRead high through the whole transfer. It checks that rxFull is cleared before the end and is set in the done cycle and afterwards.

// File: rtl/spim_pkg.sv
package spim_pkg;
  parameter int FRAME_WORD_W = 32;
  parameter int FRAME_SLOTS  = 4;
  parameter int FIDX_W = $clog2(FRAME_SLOTS);
  parameter int BIDX_W = $clog2(FRAME_WORD_W);
  parameter int LEN_W  = BIDX_W + 1;
  parameter int BUF_W  = FRAME_SLOTS * FRAME_WORD_W;

  // Control-to-datapath strobes
  typedef struct packed {
    logic              load;     // snapshot transmit store, clear receive work
    logic              sample;   // capture miso at rising SCK
    logic              finish;   // publish result
    logic              active;   // transfer in progress
    logic [FIDX_W-1:0] frameIdx;
    logic [BIDX_W-1:0] bitPos;
  } spimStrobe_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int NUM_SS = 4,
  parameter int DIV_W  = 8,
  localparam int SS_W  = (NUM_SS > 1) ? $clog2(NUM_SS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [LEN_W-1:0]  cfgFrameBits,
  input  logic              cfgLsbFirst,
  input  logic [FIDX_W-1:0] cfgFrames,
  input  logic [SS_W-1:0]   cfgSsSel,
  input  logic              cfgThreeWire,
  input  logic [DIV_W-1:0]  cfgSckHalf,
  output spimStrobe_t       strobe,
  output logic              sck,
  output logic [NUM_SS-1:0] ssN,
  output logic              busy
);
  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_TRAIL} state_t;

  state_t              state;
  logic [DIV_W-1:0]    cnt, half, halfIn;
  logic [BIDX_W-1:0]   bitIdx;
  logic [FIDX_W-1:0]   frameIdx, lastFrame;
  logic [LEN_W-1:0]    nBits;
  logic                lsbQ, threeQ;
  logic [SS_W-1:0]     ssSelQ;
  logic                tick, bitLast, frameLast;

  function automatic logic [LEN_W-1:0] legalLen(input logic [LEN_W-1:0] n);
    if ((n >= LEN_W'(8) && n <= LEN_W'(16)) || n == LEN_W'(20) ||
        n == LEN_W'(24) || n == LEN_W'(32))
      return n;
    return LEN_W'(8);
  endfunction

  assign halfIn    = (cfgSckHalf == '0) ? DIV_W'(1) : cfgSckHalf;
  assign tick      = (cnt == '0);
  assign bitLast   = ({1'b0, bitIdx} == nBits - LEN_W'(1));
  assign frameLast = (frameIdx == lastFrame);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      half      <= DIV_W'(1);
      bitIdx    <= '0;
      frameIdx  <= '0;
      lastFrame <= '0;
      nBits     <= LEN_W'(8);
      lsbQ      <= 1'b0;
      threeQ    <= 1'b0;
      ssSelQ    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          nBits     <= legalLen(cfgFrameBits);
          lsbQ      <= cfgLsbFirst;
          lastFrame <= cfgFrames;
          ssSelQ    <= cfgSsSel;
          threeQ    <= cfgThreeWire;
          half      <= halfIn;
          cnt       <= halfIn - DIV_W'(1);
          bitIdx    <= '0;
          frameIdx  <= '0;
          state     <= ST_LEAD;
        end
        ST_LEAD, ST_LOW: if (tick) begin
          cnt   <= half - DIV_W'(1);
          state <= ST_HIGH;
        end else cnt <= cnt - DIV_W'(1);
        ST_HIGH: if (tick) begin
          cnt <= half - DIV_W'(1);
          if (bitLast) begin
            bitIdx <= '0;
            if (frameLast) state <= ST_TRAIL;
            else begin
              frameIdx <= frameIdx + FIDX_W'(1);
              state    <= ST_LOW;
            end
          end else begin
            bitIdx <= bitIdx + BIDX_W'(1);
            state  <= ST_LOW;
          end
        end else cnt <= cnt - DIV_W'(1);
        ST_TRAIL: if (tick) state <= ST_IDLE;
                  else cnt <= cnt - DIV_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign sck  = (state == ST_HIGH);

  always_comb begin
    strobe.load     = (state == ST_IDLE) && startReq;
    strobe.sample   = ((state == ST_LEAD) || (state == ST_LOW)) && tick;
    strobe.finish   = (state == ST_TRAIL) && tick;
    strobe.active   = busy;
    strobe.frameIdx = frameIdx;
    strobe.bitPos   = lsbQ ? bitIdx
                           : BIDX_W'(nBits - LEN_W'(1) - {1'b0, bitIdx});
  end

  for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
    assign ssN[i] = !(busy && !threeQ && (ssSelQ == SS_W'(i)));
  end
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txWrEn,
  input  logic [FIDX_W-1:0] txWrIdx,
  input  logic [FRAME_WORD_W-1:0] txWrData,
  input  logic              rxRead,
  input  spimStrobe_t       strobe,
  input  logic              miso,
  output logic              mosi,
  output logic [BUF_W-1:0]  rxData,
  output logic              rxFull,
  output logic              done
);
  logic [FRAME_SLOTS-1:0][FRAME_WORD_W-1:0] pendTx, actTx, rxWork, rxBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendTx <= '0;
      actTx  <= '0;
      rxWork <= '0;
      rxBuf  <= '0;
      rxFull <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (txWrEn) pendTx[txWrIdx] <= txWrData;
      if (strobe.load) begin
        actTx  <= pendTx;
        rxWork <= '0;
      end else if (strobe.sample) begin
        rxWork[strobe.frameIdx][strobe.bitPos] <= miso;
      end
      done <= strobe.finish;
      if (strobe.finish) rxBuf <= rxWork;
      if (strobe.finish)  rxFull <= 1'b1;
      else if (rxRead)    rxFull <= 1'b0;
    end
  end

  assign mosi   = strobe.active & actTx[strobe.frameIdx][strobe.bitPos];
  assign rxData = rxBuf;
endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master
  import spim_pkg::*;
#(
  parameter int NUM_SS = 4,
  parameter int DIV_W  = 8,
  localparam int SS_W  = (NUM_SS > 1) ? $clog2(NUM_SS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txWrEn,
  input  logic [FIDX_W-1:0] txWrIdx,
  input  logic [FRAME_WORD_W-1:0] txWrData,
  input  logic              startReq,
  input  logic [LEN_W-1:0]  cfgFrameBits,
  input  logic              cfgLsbFirst,
  input  logic [FIDX_W-1:0] cfgFrames,
  input  logic [SS_W-1:0]   cfgSsSel,
  input  logic              cfgThreeWire,
  input  logic [DIV_W-1:0]  cfgSckHalf,
  input  logic              rxRead,
  output logic              busy,
  output logic              done,
  output logic              rxFull,
  output logic [BUF_W-1:0]  rxData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ssN
);
  spimStrobe_t strobe;

  spim_ctrl #(.NUM_SS(NUM_SS), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .cfgFrameBits(cfgFrameBits), .cfgLsbFirst(cfgLsbFirst),
    .cfgFrames(cfgFrames), .cfgSsSel(cfgSsSel),
    .cfgThreeWire(cfgThreeWire), .cfgSckHalf(cfgSckHalf),
    .strobe(strobe), .sck(sck), .ssN(ssN), .busy(busy)
  );

  spim_datapath i_dp (
    .clk(clk), .rstN(rstN), .txWrEn(txWrEn), .txWrIdx(txWrIdx),
    .txWrData(txWrData), .rxRead(rxRead), .strobe(strobe),
    .miso(miso), .mosi(mosi), .rxData(rxData), .rxFull(rxFull),
    .done(done)
  );
endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spim_pkg::*;
#(
  parameter int NUM_SS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              rxFull,
  input logic [BUF_W-1:0]  rxData,
  input logic              sck,
  input logic              mosi,
  input logic [NUM_SS-1:0] ssN
);
  assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);
  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));
  assert_one_select_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~ssN));
  assert_select_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (&ssN));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> rxFull);
  assert_end_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> done);
endmodule

bind spi_multi_master spim_checker #(.NUM_SS(NUM_SS)) i_spimChecker (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .rxFull(rxFull),
  .rxData(rxData), .sck(sck), .mosi(mosi), .ssN(ssN)
);

// File: tb/test_spi_multi_master.sv
module test_spi_multi_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic [5:0] bits;
    logic       lsb;
    logic [1:0] frames;
    logic [1:0] ss;
    logic       three;
    logic [7:0] half;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{6'd8,  1'b0, 2'd0, 2'd0, 1'b0, 8'd1},
    '{6'd16, 1'b1, 2'd1, 2'd1, 1'b0, 8'd2},
    '{6'd20, 1'b0, 2'd2, 2'd2, 1'b0, 8'd3},
    '{6'd24, 1'b1, 2'd3, 2'd3, 1'b0, 8'd1},
    '{6'd32, 1'b0, 2'd3, 2'd0, 1'b1, 8'd2},
    '{6'd13, 1'b0, 2'd1, 2'd1, 1'b0, 8'd0},
    '{6'd17, 1'b1, 2'd1, 2'd2, 1'b0, 8'd2}
  };

  logic clk = 0, rstN = 0;
  logic txWrEn = 0, startReq = 0, cfgLsbFirst = 0, cfgThreeWire = 0, rxRead = 0;
  logic [1:0] txWrIdx = 0, cfgFrames = 0, cfgSsSel = 0;
  logic [31:0] txWrData = 0;
  logic [5:0] cfgFrameBits = 8;
  logic [7:0] cfgSckHalf = 1;
  logic busy, done, rxFull, sck, mosi, miso;
  logic [127:0] rxData;
  logic [3:0] ssN;

  spi_multi_master i_spi_multi_master (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  // slave model and recorders
  logic [127:0] misoStream = '0;
  logic [7:0]   rxCnt = 0;
  int           moCnt = 0;
  logic [127:0] moRec = '0;
  logic [3:0]   ssFirst = '1;
  bit           ssBad = 0;
  time tSsFall, tSsRise, tRise1, tRise2, tFall1, tFallLast;
  logic ssAll;
  assign ssAll = &ssN;
  assign miso = misoStream[rxCnt[6:0]];

  always @(posedge sck) begin
    if (moCnt < 128) moRec[moCnt] = mosi;
    if (moCnt == 0) begin tRise1 = $time; ssFirst = ssN; end
    else if (ssN !== ssFirst) ssBad = 1;
    if (moCnt == 1) tRise2 = $time;
    moCnt = moCnt + 1;
  end
  always @(negedge sck) begin
    if (rxCnt == 0) tFall1 = $time;
    tFallLast = $time;
    rxCnt = rxCnt + 1;
  end
  always @(negedge ssAll) tSsFall = $time;
  always @(posedge ssAll) tSsRise = $time;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual cycles=%0d expected <=%0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mkData(input int seed);
    logic [127:0] d;
    for (int k = 0; k < 4; k++) d[k*32 +: 32] = 32'h9E3779B9 * (seed*4 + k + 1) ^ 32'h5A5A_0F0F;
    return d;
  endfunction

  function automatic int effBits(input logic [5:0] b);
    if ((b >= 8 && b <= 16) || b == 20 || b == 24 || b == 32) return int'(b);
    return 8;
  endfunction

  function automatic logic [127:0] expMosi(input logic [127:0] tx, input int nb, input int nf, input logic lsb);
    logic [127:0] s = '0;
    for (int j = 0; j < nb*nf; j++) begin
      int k = j / nb, b = j % nb;
      s[j] = tx[k*32 + (lsb ? b : nb-1-b)];
    end
    return s;
  endfunction

  function automatic logic [127:0] expRx(input logic [127:0] mi, input int nb, input int nf, input logic lsb);
    logic [127:0] r = '0;
    for (int k = 0; k < nf; k++)
      for (int j = 0; j < nb; j++)
        r[k*32 + (lsb ? j : nb-1-j)] = mi[k*nb + j];
    return r;
  endfunction

  task automatic loadTx(input logic [127:0] tx);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      txWrEn = 1; txWrIdx = 2'(k); txWrData = tx[k*32 +: 32];
    end
    @(negedge clk);
    txWrEn = 0;
  endtask

  task automatic launch(input vec_t v, input logic [127:0] mi);
    @(negedge clk);
    misoStream = mi; rxCnt = 0; moCnt = 0; moRec = '0; ssBad = 0;
    cfgFrameBits = v.bits; cfgLsbFirst = v.lsb; cfgFrames = v.frames;
    cfgSsSel = v.ss; cfgThreeWire = v.three; cfgSckHalf = v.half;
    startReq = 1;
    @(negedge clk);
    startReq = 0;
  endtask

  task automatic waitDone(output bit ok);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    ok = done;
  endtask

  // Called at the negedge where done is high
  task automatic checkXfer(input vec_t v, input logic [127:0] tx, input logic [127:0] mi);
    int nb = effBits(v.bits), nf = int'(v.frames) + 1;
    int h = (v.half == 0) ? 1 : int'(v.half);
    check("R1 sck pulse count", 128'(moCnt), 128'(nb*nf));
    check("R2 R3 mosi stream order/frames", moRec, expMosi(tx, nb, nf, v.lsb));
    check("R4 rxData zero-filled", rxData, expRx(mi, nb, nf, v.lsb));
    check("R9 rxFull at done", 128'(rxFull), 128'(1));
    check("R9 busy low at done", 128'(busy), 128'(0));
    if (v.three) begin
      check("R6 three-wire select", 128'({ssBad, ssFirst}), 128'(5'b0_1111));
    end else begin
      check("R6 selected line", 128'({ssBad, ssFirst}), 128'({1'b0, ~(4'b1 << v.ss)}));
      check("R8 select lead", 128'(tRise1 - tSsFall), 128'(h*CLK_PERIOD));
      check("R8 select trail", 128'(tSsRise - tFallLast), 128'(h*CLK_PERIOD));
    end
    check("R7 sck high phase", 128'(tFall1 - tRise1), 128'(h*CLK_PERIOD));
    check("R7 sck period", 128'(tRise2 - tRise1), 128'(2*h*CLK_PERIOD));
    @(negedge clk);
    check("R9 done one cycle", 128'(done), 128'(0));
  endtask

  initial begin
    bit ok;
    logic [127:0] txA, txB, mi, prevRx;
    vec_t v;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset sck", 128'(sck), 128'(0));
    check("R11 reset ssN", 128'(ssN), 128'(4'hF));
    check("R11 reset busy/done/rxFull/mosi", 128'({busy, done, rxFull, mosi}), 128'(0));
    rstN = 1;
    @(negedge clk);

    // vector table
    for (int i = 0; i < 7; i++) begin
      txA = mkData(i); mi = mkData(i + 40);
      loadTx(txA);
      launch(VECS[i], mi);
      waitDone(ok);
      check("R9 done arrives", 128'(ok), 128'(1));
      checkXfer(VECS[i], txA, mi);
      prevRx = rxData;
      @(negedge clk); rxRead = 1;
      @(negedge clk); rxRead = 0;
      check("R9 rxRead clears rxFull", 128'(rxFull), 128'(0));
    end

    // R5 double buffering: write at start edge and mid-transfer
    v = '{6'd16, 1'b0, 2'd1, 2'd0, 1'b0, 8'd2};
    txA = mkData(70); txB = txA;
    txB[31:0] = 32'hDEAD_BEEF; txB[63:32] = 32'h1234_5678;
    mi = mkData(71);
    loadTx(txA);
    @(negedge clk);
    misoStream = mi; rxCnt = 0; moCnt = 0; moRec = '0; ssBad = 0;
    cfgFrameBits = v.bits; cfgLsbFirst = v.lsb; cfgFrames = v.frames;
    cfgSsSel = v.ss; cfgThreeWire = v.three; cfgSckHalf = v.half;
    startReq = 1; txWrEn = 1; txWrIdx = 0; txWrData = 32'hDEAD_BEEF;
    @(negedge clk);
    startReq = 0; txWrIdx = 1; txWrData = 32'h1234_5678;
    @(negedge clk);
    txWrEn = 0;
    repeat (10) @(negedge clk);
    check("R4 rxData held mid-transfer", rxData, prevRx);
    waitDone(ok);
    checkXfer(v, txA, mi);
    launch(v, mi);
    waitDone(ok);
    check("R5 later transfer uses new words", expMosi(txB, 16, 2, 1'b0), moRec);

    // R10 start while busy is ignored (rxFull left set for the next test)
    launch(v, mi);
    repeat (5) @(negedge clk);
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    waitDone(ok);
    check("R10 first transfer intact", 128'(moCnt), 128'(32));
    moCnt = 0;
    repeat (40) @(negedge clk);
    check("R10 no extra transfer", 128'({busy, 8'(moCnt)}), 128'(0));

    // R9 rxRead colliding with done: set wins
    check("R9 rxFull pending", 128'(rxFull), 128'(1));
    launch(v, mi);
    rxRead = 1;
    repeat (3) @(negedge clk);
    check("R9 rxRead clears during transfer", 128'(rxFull), 128'(0));
    waitDone(ok);
    rxRead = 0;
    check("R9 set wins over rxRead", 128'(rxFull), 128'(1));
    @(negedge clk);
    check("R9 rxFull stays set", 128'(rxFull), 128'(1));

    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end
endmodule